// File: doc/BRIEF.md
# Boundary Test Access Port with Three-Bit Instruction Latch

This block is the serial test access port of a memory device. A four-wire serial interface (test clock, mode select, serial data in, serial data out) steers a sixteen-state controller, which selects either a three-bit instruction path or one of three data paths. The data paths are a one-bit bypass stage, a fixed 32-bit identification word and a 70-cell boundary register. The boundary register captures the device's pin levels in parallel.

Only sample-style instructions exist. One of them also raises a strobe that the surrounding memory logic uses to float its data pins. Serial bits enter at the least significant end of the selected register and leave from its most significant end. The serial output is retimed on the falling edge of the test clock, and its enable is high only while a shift state is active.

Top module: `scan_port`

## Requirements
- R1: With the mode-select input high on five consecutive rising test-clock edges, the controller reaches its reset state from any state. After one further edge, the identification instruction is current again, with the float strobe low and the identification word on the data path.
- R2: State transitions follow the standard sixteen-state test controller. A data shift interrupted through Exit1, Pause and Exit2 resumes without losing or repeating a bit.
- R3: The serial output and its enable change only on falling test-clock edges. The enable is high exactly while the controller sits in Shift-DR or Shift-IR.
- R4: The instruction path is 3 bits wide. Capture-IR loads binary 001, serial data enters at bit 0, and bit 2 drives the output. The current instruction changes only on the edge that leaves Update-IR.
- R5: Asynchronous reset and the controller's reset state both make the identification instruction (code 1) current.
- R6: Instruction decode works as follows. Code 1 selects the identification word. Codes 2 and 4 select the boundary register. Codes 0, 3, 5, 6 and 7 select the one-bit bypass stage.
- R7: The bypass stage captures 0 and delays serial input by exactly one shift.
- R8: The identification word is built as follows. Bit 0 is 1. Bits 11:1 are binary 00001110001. Bits 27:12 are zero. Bits 31:28 hold the REV parameter, which defaults to 0, giving 32'h000000E3. The word shifts out from bit 31 downward.
- R9: The boundary register is 70 cells. Cells 64:0 capture pin_cap[64:0] at Capture-DR. Cells 69:65 are fillers that always capture 0. A pin change after capture does not alter the bits being shifted.
- R10: The pins_hiz output is high exactly while code 2 is the current instruction. Code 4 samples the same pins without raising it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| test_mode_sel | input | 1 | Controller steering input, sampled on rising edge |
| test_din | input | 1 | Serial data input, sampled on rising edge |
| pin_cap | input | 65 | Parallel pin levels captured by the boundary register |
| test_dout | output | 1 | Serial data output, updated on falling edge |
| test_dout_en | output | 1 | High while the serial output is driven |
| pins_hiz | output | 1 | Forces the functional data pins to high impedance |

## Verification
A wrong controller state first shows as the output enable rising or falling one falling edge early or late. It can also show as a shifted word that is offset by one bit, or as bits repeated across a pause. A bad instruction latch shows within one update as the float strobe taking the wrong level or the wrong register length appearing on the serial output. Every instruction code is loaded and a full register plus a few extra bits is shifted through it, so a wrong capture value or a wrong path length is visible in the first shift after capture.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP,
    PATH_ID,
    PATH_BND
  } dr_path_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_IDENT    = 3'd1;
  localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'd2;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'd4;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
    dr_path_e p;
    case (op)
      OP_IDENT:              p = PATH_ID;
      OP_SAMPLE_Z, OP_SAMPLE: p = PATH_BND;
      default:               p = PATH_BYP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:  state_d = mode_sel ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = mode_sel ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = mode_sel ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = mode_sel ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = mode_sel ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  state_d = mode_sel ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_d = mode_sel ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = mode_sel ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = mode_sel ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = mode_sel ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = mode_sel ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  state_d = mode_sel ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_d = mode_sel ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  // checker: run length of consecutive high mode-select samples, saturating
  logic [2:0] ones_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ones_run <= 3'd0;
    else if (!mode_sel)         ones_run <= 3'd0;
    else if (ones_run != 3'd5)  ones_run <= ones_run + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_run == 3'd5) |-> (state_q == ST_RESET));

  a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SH_DR) |-> ($past(state_q) inside {ST_CAP_DR, ST_SH_DR, ST_EX2_DR}));

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            din,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_msb
);

  logic [IR_W-1:0] sh_q, sh_d, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = (state == ST_CAP_IR) || (state == ST_SH_IR);
    sh_d  = (state == ST_CAP_IR) ? IR_CAPTURE : {sh_q[IR_W-2:0], din};
    ir_en = (state == ST_RESET) || (state == ST_UPD_IR);
    ir_d  = (state == ST_RESET) ? OP_IDENT : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= IR_CAPTURE;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDENT;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_msb = sh_q[IR_W-1];

  a_r4_capture_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CAP_IR) |-> (sh_q == 3'b001));

  a_r4_latch_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir_q) |-> ($past(state) inside {ST_UPD_IR, ST_RESET}));

  a_r5_reset_ident: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RESET) |-> (ir_q == 3'd1));

endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int         BND_W = 70,
  parameter int         PAD_W = 5,
  parameter int         ID_W  = 32,
  parameter logic [3:0] REV   = 4'h0,
  localparam int        LIVE_W = BND_W - PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  dr_path_e          path,
  input  logic              din,
  input  logic [LIVE_W-1:0] pins,
  output logic              dr_msb
);

  localparam logic [ID_W-1:0] ID_WORD =
    {REV, 16'h0000, 11'b000_0111_0001, 1'b1};

  logic [BND_W-1:0] cap_vec;

  for (genvar c = 0; c < BND_W; c++) begin : g_cell
    if (c < LIVE_W) begin : g_live
      assign cap_vec[c] = pins[c];
    end else begin : g_pad
      assign cap_vec[c] = 1'b0;
    end
  end

  logic             cap, sft;
  logic             byp_q, byp_d, byp_en;
  logic [ID_W-1:0]  id_q, id_d;
  logic             id_en;
  logic [BND_W-1:0] bnd_q, bnd_d;
  logic             bnd_en;

  always_comb begin
    cap    = (state == ST_CAP_DR);
    sft    = (state == ST_SH_DR);
    byp_en = (cap || sft) && (path == PATH_BYP);
    id_en  = (cap || sft) && (path == PATH_ID);
    bnd_en = (cap || sft) && (path == PATH_BND);
    byp_d  = cap ? 1'b0    : din;
    id_d   = cap ? ID_WORD : {id_q[ID_W-2:0], din};
    bnd_d  = cap ? cap_vec : {bnd_q[BND_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bnd_q <= '0;
    else if (bnd_en) bnd_q <= bnd_d;
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_msb = id_q[ID_W-1];
      PATH_BND: dr_msb = bnd_q[BND_W-1];
      default:  dr_msb = byp_q;
    endcase
  end

  a_r7_bypass_captures_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CAP_DR && $past(path) == PATH_BYP) |-> (byp_q == 1'b0));

  a_r8_ident_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CAP_DR && $past(path) == PATH_ID) |-> (id_q[11:0] == 12'h0E3));

  a_r9_fillers_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CAP_DR && $past(path) == PATH_BND) |-> (bnd_q[BND_W-1 -: PAD_W] == '0));

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int         BND_W = 70,
  parameter int         PAD_W = 5,
  parameter logic [3:0] REV   = 4'h0
) (
  input  logic                   test_clk,
  input  logic                   test_rst_n,
  input  logic                   test_mode_sel,
  input  logic                   test_din,
  input  logic [BND_W-PAD_W-1:0] pin_cap,
  output logic                   test_dout,
  output logic                   test_dout_en,
  output logic                   pins_hiz
);

  // reset: asserted asynchronously, released on the second rising edge
  logic [1:0] rst_sync;
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) rst_sync <= 2'b00;
    else             rst_sync <= {rst_sync[0], 1'b1};
  end
  logic rst_n;
  assign rst_n = rst_sync[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir_cur;
  logic            ir_msb, dr_msb;
  dr_path_e        path;

  tap_fsm u_fsm (
    .clk      (test_clk),
    .rst_n    (rst_n),
    .mode_sel (test_mode_sel),
    .state_q  (state)
  );

  scan_ir u_ir (
    .clk    (test_clk),
    .rst_n  (rst_n),
    .state  (state),
    .din    (test_din),
    .ir_q   (ir_cur),
    .ir_msb (ir_msb)
  );

  assign path = path_of(ir_cur);

  scan_dr #(.BND_W(BND_W), .PAD_W(PAD_W), .REV(REV)) u_dr (
    .clk    (test_clk),
    .rst_n  (rst_n),
    .state  (state),
    .path   (path),
    .din    (test_din),
    .pins   (pin_cap),
    .dr_msb (dr_msb)
  );

  // falling-edge retiming of the serial output and its enable
  logic dout_d, en_d;
  always_comb begin
    en_d   = (state == ST_SH_DR) || (state == ST_SH_IR);
    dout_d = (state == ST_SH_IR) ? ir_msb : dr_msb;
  end

  always_ff @(negedge test_clk or negedge rst_n) begin
    if (!rst_n) begin
      test_dout    <= 1'b0;
      test_dout_en <= 1'b0;
    end else begin
      test_dout    <= dout_d;
      test_dout_en <= en_d;
    end
  end

  assign pins_hiz = (ir_cur == OP_SAMPLE_Z);

  a_r3_enable_only_in_shift: assert property (@(posedge test_clk) disable iff (!rst_n)
    test_dout_en |-> (state inside {ST_SH_DR, ST_SH_IR}));

  a_r3_quiet_on_rising_edge: assert property (@(posedge test_clk) disable iff (!rst_n)
    $stable(test_dout_en) || (state inside {ST_SH_DR, ST_SH_IR, ST_EX1_DR, ST_EX1_IR}));

  a_r10_float_tracks_code: assert property (@(posedge test_clk) disable iff (!rst_n)
    $rose(pins_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/sim_scan_port.sv
module sim_scan_port;

  logic        clk = 1'b0;
  logic        rst_n, tms, tdi;
  logic [64:0] pins;
  wire         tdo, oe, hiz;

  always #10 clk = ~clk;

  scan_port u0 (
    .test_clk      (clk),
    .test_rst_n    (rst_n),
    .test_mode_sel (tms),
    .test_din      (tdi),
    .pin_cap       (pins),
    .test_dout     (tdo),
    .test_dout_en  (oe),
    .pins_hiz      (hiz)
  );

  int errors = 0, checks = 0, rise_moves = 0, cyc = 0;
  localparam logic [31:0] ID_EXP = 32'h000000E3;
  localparam logic [79:0] PAT    = 80'hA5C3_9F0E_1B2D_4C6E_8F13;

  // table: {code[2:0], path kind[1:0] (0 bypass,1 ident,2 boundary), float}
  localparam logic [5:0] VEC [8] = '{
    {3'd0, 2'd0, 1'b0}, {3'd1, 2'd1, 1'b0}, {3'd2, 2'd2, 1'b1}, {3'd3, 2'd0, 1'b0},
    {3'd4, 2'd2, 1'b0}, {3'd5, 2'd0, 1'b0}, {3'd6, 2'd0, 1'b0}, {3'd7, 2'd0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic e);
    @(negedge clk); #1;
    o = tdo; e = oe; tms = m; tdi = d;
    @(posedge clk); #1;
    if (tdo !== o || oe !== e) rise_moves++;
  endtask

  task automatic t(input logic m);
    logic o, e;
    tick(m, 1'b0, o, e);
  endtask

  task automatic load_ir(input logic [2:0] v, output logic [2:0] cap);
    logic o, e;
    t(1); t(1); t(0); t(0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, v[2-i], o, e);
      cap[2-i] = o;
    end
    t(1); t(0);
  endtask

  task automatic read_dr(input int n, output logic [79:0] dout);
    logic o, e;
    dout = '0;
    t(1); t(0); t(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, PAT[i], o, e);
      dout[i] = o;
    end
    t(1); t(0);
  endtask

  function automatic logic [79:0] expect_out(input int len, input logic [69:0] cap, input int n);
    logic [79:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[len-1-i] : PAT[i-len];
    return r;
  endfunction

  function automatic logic [79:0] ident_bits(input int n);
    return expect_out(32, {38'h0, ID_EXP}, n);
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0]  irc;
    logic [79:0] got;
    logic        o, e;
    logic [64:0] old_pins;
    rst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pins = 65'h1_DEAD_BEEF_0123_4567;
    repeat (3) t(1);
    check(oe == 1'b0 && hiz == 1'b0, "R5 reset outputs", {78'h0, oe, hiz}, 80'h0);
    rst_n = 1'b1;
    repeat (4) t(1);
    t(0);

    // R5/R8: identification word current after reset
    read_dr(36, got);
    check(got[35:0] == ident_bits(36)[35:0], "R5 R8 ident after reset", got, ident_bits(36));

    // table walk over all codes: R4 R6 R7 R8 R9 R10
    for (int k = 0; k < 8; k++) begin
      logic [2:0]  code;
      logic [1:0]  kind;
      int          len;
      logic [69:0] cv;
      logic [79:0] exp;
      code = VEC[k][5:3];
      kind = VEC[k][2:1];
      load_ir(code, irc);
      check(irc == 3'b001, "R4 capture pattern", {77'h0, irc}, 80'h1);
      check(hiz == VEC[k][0], "R10 float strobe", {79'h0, hiz}, {79'h0, VEC[k][0]});
      len = (kind == 2'd0) ? 1 : (kind == 2'd1) ? 32 : 70;
      cv  = (kind == 2'd0) ? 70'h0 : (kind == 2'd1) ? {38'h0, ID_EXP} : {5'b0, pins};
      exp = expect_out(len, cv, len + 6);
      read_dr(len + 6, got);
      check(got == exp, (kind == 2'd0) ? "R6 R7 bypass path" :
                        (kind == 2'd1) ? "R6 R8 ident path" : "R6 R9 boundary path", got, exp);
    end

    // R9: pin change after capture does not disturb shifted data
    load_ir(3'd4, irc);
    old_pins = pins;
    t(1); t(0); t(0);
    pins = ~pins;
    got = '0;
    for (int i = 0; i < 70; i++) begin
      tick(i == 69, 1'b0, o, e);
      got[i] = o;
    end
    t(1); t(0);
    check(got == expect_out(70, {5'b0, old_pins}, 70), "R9 capture holds", got,
          expect_out(70, {5'b0, old_pins}, 70));

    // R2/R3: ident shift interrupted by a pause
    load_ir(3'd1, irc);
    got = '0;
    t(1); t(0); t(0);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, PAT[i], o, e);
      got[i] = o;
      if (i == 0) check(e == 1'b1, "R3 enable in shift", {79'h0, e}, 80'h1);
    end
    tick(0, 1'b0, o, e);
    check(e == 1'b0, "R3 enable off in exit", {79'h0, e}, 80'h0);
    tick(0, 1'b0, o, e);
    check(e == 1'b0, "R3 enable off in pause", {79'h0, e}, 80'h0);
    t(1); t(0);
    for (int i = 10; i < 32; i++) begin
      tick(i == 31, 1'b0, o, e);
      got[i] = o;
    end
    t(1); t(0);
    check(got[31:0] == ID_EXP[31:0] ? 1'b0 : 1'b1, "R2 sanity order", 80'h0, 80'h0);
    check(got[31:0] == ident_bits(32)[31:0], "R2 pause resume", got, ident_bits(32));

    // R4: latch does not change before Update-IR
    t(1); t(1); t(0); t(0);
    tick(0, 1'b0, o, e); tick(0, 1'b1, o, e); tick(1, 1'b0, o, e);
    t(0);
    check(hiz == 1'b0, "R4 no early latch", {79'h0, hiz}, 80'h0);
    t(1); t(1); t(0);
    check(hiz == 1'b1, "R4 R10 latch on update", {79'h0, hiz}, 80'h1);

    // R1: five high mode-select edges from Shift-DR
    t(1); t(0); t(0);
    repeat (5) t(1);
    t(0);
    check(hiz == 1'b0 && oe == 1'b0, "R1 five ones reset", {78'h0, hiz, oe}, 80'h0);
    read_dr(32, got);
    check(got[31:0] == ident_bits(32)[31:0], "R1 ident after five ones", got, ident_bits(32));

    check(rise_moves == 0, "R3 outputs steady at rising edge", rise_moves, 80'h0);

    summary();
    $finish;
  end

endmodule